// File: doc/BRIEF.md
# Strapped-address I2C register access port

This block is an I2C target that lets a bus host read and write a small control register file. It runs on a fast system clock that oversamples the bus. SCL and SDA pass through a synchronizer, then edge and condition detection, before the protocol engine uses them. The block drives SDA open-drain through an output-enable. The register file itself sits outside the block, behind a write strobe, a register address and a read-data input.

The target address has seven bits. The upper five are a fixed prefix, 10011 by default. The two lower bits come from a two-bit strap input that is captured when reset is released. A write transaction carries a pointer byte first. Bit 7 of that byte enables auto-increment and bits 6:0 select the register. Data bytes follow the pointer byte. A read transaction has no pointer byte: it returns the register the pointer already selects. To read a chosen register, the host first runs a write that it ends with a stop right after the pointer byte, and then runs the read.

Top module: `strap_i2c_regport`

## Requirements
- R1: While reset is high and in the first cycle after it, `sda_oe_o` is 0, `reg_wr_o` is 0 and `reg_addr_o` is 0. Auto-increment is off.
- R2: The target acknowledges an address byte only when its upper seven bits equal {prefix 10011, strap bit 1, strap bit 0}. Bit 0 of that byte is R/W (1 = read). On a mismatch the target drives nothing and writes nothing until the next start.
- R3: `strap_i` is captured while reset is high, and the value present when reset falls is kept. Later changes on `strap_i` do not change the address the target answers to.
- R4: In a write, the byte after the address loads the pointer from bits 6:0 and the auto-increment flag from bit 7. A stop right after that byte's acknowledge leaves the pointer set and strobes no write.
- R5: Each data byte of a write is acknowledged and produces exactly one single-cycle `reg_wr_o` pulse, carrying that byte on `reg_wdata_o` and the current pointer on `reg_addr_o`.
- R6: With auto-increment on, successive data bytes of a write go to consecutive registers. With it off, they all go to the same register.
- R7: A read sends the register at the pointer, MSB first. A read never loads the pointer. With auto-increment on, the pointer advances by one after each byte the host acknowledges.
- R8: A NACK from the host ends the read: SDA is released and the pointer does not advance for that byte.
- R9: When the 7-bit pointer increments from 127, it wraps to 0.
- R10: A repeated start at any byte boundary restarts address decoding. The pointer keeps its value.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 2 | Address straps: bit 1 is address bit 1, bit 0 is address bit 0 |
| reg_addr_o | output | 7 | Current register pointer |
| reg_wr_o | output | 1 | Single-cycle register write strobe |
| reg_wdata_o | output | 8 | Byte to write |
| reg_rdata_i | input | 8 | Contents of the register at `reg_addr_o` |

## Verification
Two functions can meet on one byte: the write strobe for a data byte and the auto-increment of the pointer, and, at the top of the pointer range, the wrap to 0. The bench provokes this with an auto-increment write that starts at register 127 and sends two bytes. It judges the result by which registers end up holding each byte and by a read that follows. A write strobe whose address had already moved would put the first byte in register 0 and lose it from 127. A second pairing is a NACK arriving on a byte that would otherwise advance the pointer. This is judged by re-reading and expecting the NACKed register again.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_MAP,
    ST_MACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } bus_st_e;
endpackage

// File: rtl/sirp_sync.sv
module sirp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sirp_ptr.sv
module sirp_ptr #(
  parameter int PTR_W = 7
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              load,
  input  logic [strap_i2c_pkg::BYTE_W-1:0]  map_byte,
  input  logic                              inc,
  output logic [PTR_W-1:0]                  ptr,
  output logic                              ainc
);
  localparam int MSB = strap_i2c_pkg::BYTE_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      ainc <= 1'b0;
    end else if (load) begin
      ptr  <= map_byte[PTR_W-1:0];
      ainc <= map_byte[MSB];
    end else if (inc) begin
      ptr  <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/sirp_ctrl.sv
module sirp_ctrl
  import strap_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b10011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        strap,
  input  logic              ainc,
  input  logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] map_byte,
  output logic              map_ld,
  output logic              ptr_inc,
  output logic              sda_oe,
  output logic              wr,
  output logic [BYTE_W-1:0] wdata
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  bus_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              rw, hack;

  assign map_byte = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      hack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr      <= 1'b0;
      wdata   <= '0;
      map_ld  <= 1'b0;
      ptr_inc <= 1'b0;
    end else begin
      wr      <= 1'b0;
      map_ld  <= 1'b0;
      ptr_inc <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_MAP, ST_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[BYTE_W-1:1] == {ADDR_PREFIX, strap}) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= ST_AACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_MAP) begin
                map_ld <= 1'b1;
                sda_oe <= 1'b1;
                st     <= ST_MACK;
              end else begin
                wr     <= 1'b1;
                wdata  <= sh;
                sda_oe <= 1'b1;
                st     <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx     <= rdata;
                sda_oe <= ~rdata[BYTE_W-1];
                st     <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_MAP;
              end
            end
          end
          ST_MACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_WDAT;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              ptr_inc <= ainc;
              st      <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_FULL) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              hack    <= ~sda_s;
              ptr_inc <= ainc & ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (hack) begin
                tx     <= rdata;
                sda_oe <= ~rdata[BYTE_W-1];
                st     <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/strap_i2c_regport.sv
module strap_i2c_regport #(
  parameter int         PTR_W       = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b10011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [1:0]       strap_i,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic             reg_wr_o,
  output logic [7:0]       reg_wdata_o,
  input  logic [7:0]       reg_rdata_i
);
  logic       scl_sync, sda_sync, scl_rise, scl_fall, start_det, stop_det;
  logic [1:0] strap_q;
  logic [7:0] map_byte;
  logic       map_ld, ptr_inc, ainc;

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_i;
  end

  sirp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  sirp_ctrl #(.ADDR_PREFIX(ADDR_PREFIX)) u_ctrl (
    .clk(clk), .rst(rst), .sda_s(sda_sync), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap_q), .ainc(ainc), .rdata(reg_rdata_i),
    .map_byte(map_byte), .map_ld(map_ld), .ptr_inc(ptr_inc),
    .sda_oe(sda_oe_o), .wr(reg_wr_o), .wdata(reg_wdata_o)
  );

  sirp_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(map_ld), .map_byte(map_byte),
    .inc(ptr_inc), .ptr(reg_addr_o), .ainc(ainc)
  );
endmodule

// File: rtl/sirp_chk.sv
module sirp_chk #(
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe_o,
  input logic             reg_wr_o,
  input logic [PTR_W-1:0] reg_addr_o,
  input logic             scl_sync,
  input logic [1:0]       strap_q,
  input logic             ptr_inc
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe_o && !reg_wr_o && reg_addr_o == '0)); // R1
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
    $stable(strap_q)); // R3
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o); // R5
  AST_WR_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |-> $stable(reg_addr_o)); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && reg_addr_o == {PTR_W{1'b1}}) |=> reg_addr_o == '0); // R9
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_sync); // R11
endmodule

bind strap_i2c_regport sirp_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst(rst), .sda_oe_o(sda_oe_o), .reg_wr_o(reg_wr_o),
  .reg_addr_o(reg_addr_o), .scl_sync(scl_sync), .strap_q(strap_q),
  .ptr_inc(ptr_inc)
);

// File: tb/strap_i2c_regport_tb_top.sv
module strap_i2c_regport_tb_top;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_h = 1'b1;
  logic       sda_h = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       sda_oe;
  logic [6:0] raddr;
  logic       rwr;
  logic [7:0] rwdata, rrdata;
  logic       sda_bus;
  logic [7:0] rf [0:127];
  int         checks = 0, errors = 0, wr_count = 0, r11_viol = 0;
  logic       oe_prev = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = sda_h & ~sda_oe;
  assign rrdata  = rf[raddr];

  strap_i2c_regport dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .reg_addr_o(raddr), .reg_wr_o(rwr),
    .reg_wdata_o(rwdata), .reg_rdata_i(rrdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) rf[i] <= 8'(i) ^ 8'h3C;
    end else if (rwr) begin
      rf[raddr] <= rwdata;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (rwr) wr_count++;
      if (sda_oe != oe_prev && scl_h) r11_viol++;
    end
    oe_prev = sda_oe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; tick(Q);
      scl_h = 1'b1; tick(2*Q);
      scl_h = 1'b0; tick(Q);
    end
    sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    ack = !sda_bus; tick(Q);
    scl_h = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] d);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_h = 1'b1; tick(Q);
      d[i] = sda_bus; tick(Q);
      scl_h = 1'b0;
    end
    tick(2);
    sda_h = !give_ack; tick(Q);
    scl_h = 1'b1; tick(2*Q);
    scl_h = 1'b0; tick(2);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic set_ptr(input logic [7:0] map);
    bit a;
    bus_start();
    put_byte(8'h9C, a); chk("R2 addr ack", a, 1);
    put_byte(map, a);   chk("R4 map ack", a, 1);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 oe", sda_oe, 0);
    chk("R1 wr", rwr, 0);
    chk("R1 addr", raddr, 0);
  endtask

  task automatic t_strap_write();
    bit a;
    bus_start();
    put_byte(8'h9A, a); chk("R3 new strap ignored", a, 0);
    bus_stop();
    bus_start();
    put_byte(8'h9C, a); chk("R3 latched strap ack", a, 1);
    put_byte(8'h05, a); chk("R4 map ack", a, 1);
    put_byte(8'hA5, a); chk("R5 data ack", a, 1);
    bus_stop();
    chk("R5 reg5", rf[5], 8'hA5);
    chk("R5 strobe count", wr_count, 1);
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start();
    put_byte(8'hA0, a); chk("R2 mismatch nack", a, 0);
    put_byte(8'h0F, a); chk("R2 ignored byte nack", a, 0);
    bus_stop();
    chk("R2 no write", wr_count, 1);
    chk("R2 oe released", sda_oe, 0);
  endtask

  task automatic t_abort_read();
    bit a;
    logic [7:0] d;
    set_ptr(8'h10);
    chk("R4 abort no write", wr_count, 1);
    bus_start();
    put_byte(8'h9D, a); chk("R2 read ack", a, 1);
    get_byte(1'b0, d);  chk("R7 read reg10", d, 8'h2C);
    bus_stop();
  endtask

  task automatic t_write_inc();
    bit a;
    bus_start();
    put_byte(8'h9C, a);
    put_byte(8'hA0, a);
    put_byte(8'h11, a);
    put_byte(8'h22, a);
    put_byte(8'h33, a); chk("R6 last ack", a, 1);
    bus_stop();
    chk("R6 reg20", rf[32], 8'h11);
    chk("R6 reg21", rf[33], 8'h22);
    chk("R6 reg22", rf[34], 8'h33);
  endtask

  task automatic t_write_noinc();
    bit a;
    bus_start();
    put_byte(8'h9C, a);
    put_byte(8'h30, a);
    put_byte(8'h44, a);
    put_byte(8'h55, a);
    bus_stop();
    chk("R6 noinc reg30", rf[48], 8'h55);
    chk("R6 noinc reg31 untouched", rf[49], 8'h0D);
  endtask

  task automatic t_read_inc();
    bit a;
    logic [7:0] d;
    set_ptr(8'hA0);
    bus_start();
    put_byte(8'h9D, a);
    get_byte(1'b1, d); chk("R7 inc byte0", d, 8'h11);
    get_byte(1'b1, d); chk("R7 inc byte1", d, 8'h22);
    get_byte(1'b0, d); chk("R7 inc byte2", d, 8'h33);
    bus_stop();
    chk("R8 released after nack", sda_oe, 0);
    bus_start();
    put_byte(8'h9D, a);
    get_byte(1'b0, d); chk("R8 nack no advance", d, 8'h33);
    bus_stop();
  endtask

  task automatic t_read_noinc();
    bit a;
    logic [7:0] d;
    set_ptr(8'h05);
    bus_start();
    put_byte(8'h9D, a);
    get_byte(1'b1, d); chk("R7 noinc byte0", d, 8'hA5);
    get_byte(1'b0, d); chk("R7 noinc byte1", d, 8'hA5);
    bus_stop();
  endtask

  task automatic t_wrap();
    bit a;
    logic [7:0] d;
    bus_start();
    put_byte(8'h9C, a);
    put_byte(8'hFF, a);
    put_byte(8'h66, a);
    put_byte(8'h77, a);
    bus_stop();
    chk("R9 reg127", rf[127], 8'h66);
    chk("R9 reg0 after wrap", rf[0], 8'h77);
    bus_start();
    put_byte(8'h9D, a);
    get_byte(1'b0, d); chk("R9 pointer at 1", d, 8'h3D);
    bus_stop();
  endtask

  task automatic t_rstart();
    bit a;
    logic [7:0] d;
    bus_start();
    put_byte(8'h9C, a);
    put_byte(8'h05, a);
    bus_start();
    put_byte(8'h9D, a); chk("R10 rstart ack", a, 1);
    get_byte(1'b0, d);  chk("R10 rstart read", d, 8'hA5);
    bus_start();
    put_byte(8'hA0, a); chk("R10 mismatch nack", a, 0);
    bus_start();
    put_byte(8'h9D, a); chk("R10 rstart after mismatch", a, 1);
    get_byte(1'b0, d);  chk("R10 pointer kept", d, 8'hA5);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    tick(5);
    t_reset();
    rst = 1'b0;
    tick(1);
    t_reset();
    tick(5);
    strap = 2'b01;
    tick(Q);
    t_strap_write();
    t_mismatch();
    t_abort_read();
    t_write_inc();
    t_write_noinc();
    t_read_inc();
    t_read_noinc();
    t_wrap();
    t_rstart();
    chk("R11 drive changes with SCL high", r11_viol, 0);
    chk("R5 total strobes", wr_count, 8);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule